// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address presented to a memory pipeline on each cycle of a four-beat burst. A single external address is captured on a load cycle. Each following advance cycle steps an internal two-bit beat count, so one supplied address covers four consecutive data cycles. Only the two lowest address bits move during a burst. All higher bits keep the value captured at load.

A static mode input selects the visiting order of the four words. Linear order counts the low bits upward and wraps modulo four. Interleaved order forms the low bits as the XOR of the captured low bits and the beat count. A single advance/load control is sampled on every enabled clock edge. A clock enable freezes the whole sequencer, and every other input is ignored while it is low.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the sequencer leaves reset two clock edges after the input goes high.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `word_addr` is all zeros and the beat count is zero.
- R2: On a clock edge with `clk_en`=1 and `adv_ld`=0, `ext_addr` is captured, the beat count returns to zero, and from that edge `word_addr` equals the captured address.
- R3: On a clock edge with `clk_en`=1 and `adv_ld`=1, the beat count increases by one and `ext_addr` has no effect on `word_addr`.
- R4: With `order_intlv`=0 (linear), `word_addr[1:0]` equals (captured low bits + beat count) modulo 4, for example 2, 3, 0, 1.
- R5: With `order_intlv`=1 (interleaved), `word_addr[1:0]` equals the captured low bits XOR the beat count, for example 1, 0, 3, 2.
- R6: `word_addr[ADDR_W-1:2]` does not change on advance cycles and equals the captured upper bits.
- R7: Advancing past the fourth beat wraps the beat count from 3 to 0, so `word_addr` returns to the captured address after four advances in either order.
- R8: On a clock edge with `clk_en`=0, the sequencer keeps its state whatever `adv_ld` and `ext_addr` carry, and `word_addr` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clk_en | input | 1 | Clock enable; 0 freezes the sequencer |
| adv_ld | input | 1 | 0 loads `ext_addr`, 1 advances the beat |
| order_intlv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External word address captured on load |
| word_addr | output | ADDR_W | Word address for the current beat |

## Verification
The assertions check the following on every enabled cycle:
- a load makes `word_addr` equal to the address just supplied;
- a frozen cycle leaves `word_addr` untouched;
- an advance steps the beat by one, wraps it from 3 to 0, and keeps the upper bits fixed;
- in linear mode the low bits step by one, and in interleaved mode the low bits XOR the beat count stays constant.

Only the bench's scenarios can show that whole sequences are correct. It sweeps every start offset in both orders. It compares each beat with values computed arithmetically. It confirms the return to the start after four advances. It also shows that load attempts and new external addresses during frozen or advance cycles leave no trace on the output.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_INTLV  = 1'b1
  } order_e;

  // Low address bits for a given beat under the chosen order.
  function automatic beat_t map_low(input order_e ord, input beat_t start, input beat_t beat);
    beat_t res;
    if (ord == ORD_INTLV) begin
      res = start ^ beat;
    end else begin
      res = start + beat;
    end
    return res;
  endfunction

endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clk_en,
  input  logic  load,
  output beat_t beat
);

  beat_t beat_q;
  beat_t beat_d;

  always_comb begin
    beat_d = beat_q;
    if (clk_en) begin
      if (load) begin
        beat_d = '0;
      end else begin
        beat_d = beat_q + beat_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

  assign beat = beat_q;

endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (clk_en && load) begin
      base_d = ext_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

  assign base = base_q;

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              order_intlv,
  input  logic [ADDR_W-1:0] base,
  input  beat_t             beat,
  output logic [ADDR_W-1:0] word_addr
);

  order_e ord;
  assign ord = order_e'(order_intlv);

  assign word_addr[BEAT_W-1:0] = map_low(ord, base[BEAT_W-1:0], beat);

  generate
    if (ADDR_W > BEAT_W) begin : g_upper
      assign word_addr[ADDR_W-1:BEAT_W] = base[ADDR_W-1:BEAT_W];
    end
  endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              adv_ld,
  input  logic              order_intlv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] word_addr
);

  logic              rst_sync_n;
  logic              load;
  beat_t             beat_q;
  logic [ADDR_W-1:0] base_q;

  assign load = ~adv_ld;

  bseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  bseq_beat_ctr u_beat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clk_en (clk_en),
    .load   (load),
    .beat   (beat_q)
  );

  bseq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clk_en   (clk_en),
    .load     (load),
    .ext_addr (ext_addr),
    .base     (base_q)
  );

  bseq_order_map #(.ADDR_W(ADDR_W)) u_map (
    .order_intlv (order_intlv),
    .base        (base_q),
    .beat        (beat_q),
    .word_addr   (word_addr)
  );

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_q,
  input logic              clk_en,
  input logic              adv_ld,
  input logic              order_intlv,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] word_addr,
  input logic [1:0]        beat
);

  // R2: a load shows the supplied address from the next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (clk_en && !adv_ld) |=> (word_addr == $past(ext_addr)));

  // R3: an advance steps the beat by one
  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (clk_en && adv_ld) |=> (beat == $past(beat) + 2'd1));

  // R4: linear order steps the low bits by one
  p_linear_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (clk_en && adv_ld && !order_intlv) |=>
      (order_intlv || (word_addr[1:0] == $past(word_addr[1:0]) + 2'd1)));

  // R5: interleaved order keeps low bits XOR beat constant
  p_intlv_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (clk_en && adv_ld && order_intlv) |=>
      (!order_intlv || ((word_addr[1:0] ^ beat) == ($past(word_addr[1:0]) ^ $past(beat)))));

  // R6: upper bits fixed while advancing
  p_upper_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (clk_en && adv_ld) |=> (word_addr[ADDR_W-1:2] == $past(word_addr[ADDR_W-1:2])));

  // R7: the beat wraps from 3 to 0
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (clk_en && adv_ld && beat == 2'd3) |=> (beat == 2'd0));

  // R8: frozen cycles keep the output
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !clk_en |=> ((order_intlv != $past(order_intlv)) || (word_addr == $past(word_addr))));

endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_sync_n),
  .clk_en      (clk_en),
  .adv_ld      (adv_ld),
  .order_intlv (order_intlv),
  .ext_addr    (ext_addr),
  .word_addr   (word_addr),
  .beat        (beat_q)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

  localparam int AW = 20;

  logic          clk;
  logic          rst_n;
  logic          clk_en;
  logic          adv_ld;
  logic          order_intlv;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] word_addr;

  int checks;
  int failures;
  bit done;

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .adv_ld      (adv_ld),
    .order_intlv (order_intlv),
    .ext_addr    (ext_addr),
    .word_addr   (word_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample just after the next rising edge.
  task automatic cyc(input logic ce, input logic adv, input logic [AW-1:0] a);
    @(negedge clk);
    clk_en   = ce;
    adv_ld   = adv;
    ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] start, input logic ord,
                                                input int beat);
    logic [1:0] lo;
    lo = ord ? (start[1:0] ^ 2'(beat)) : 2'((int'(start[1:0]) + beat) % 4);
    return {start[AW-1:2], lo};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    clk_en = 1'b0;
    adv_ld = 1'b1;
    order_intlv = 1'b0;
    ext_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b1, '0);
    // R1: cleared after reset
    chk("R1 reset", word_addr, '0);
    // R1: advance from reset state walks from zero
    cyc(1'b1, 1'b1, 20'hFFFFF);
    chk("R1 beat zero after reset", word_addr, 20'h00001);

    for (int ord = 0; ord < 2; ord++) begin
      @(negedge clk);
      order_intlv = ord[0];
      for (int st = 0; st < 4; st++) begin
        logic [AW-1:0] start;
        start = AW'((st * 20'h1F3C5) ^ (ord * 20'hA5A50)) & ~AW'(3) | AW'(st);
        cyc(1'b1, 1'b0, start);
        chk("R2 load", word_addr, start);
        for (int b = 1; b <= 7; b++) begin
          cyc(1'b1, 1'b1, ~start);
          chk(ord ? "R5 interleaved beat (R3,R6)" : "R4 linear beat (R3,R6)",
              word_addr, expect_addr(start, ord[0], b % 4));
          if (b == 4) chk("R7 wrap to start", word_addr, start);
          if (b == 2) begin
            cyc(1'b0, 1'b0, start ^ 20'h5A5A5);
            chk("R8 frozen load ignored", word_addr, expect_addr(start, ord[0], 2));
            cyc(1'b0, 1'b1, 20'h00000);
            chk("R8 frozen advance ignored", word_addr, expect_addr(start, ord[0], 2));
          end
        end
      end
    end

    // R6: upper bits with all ones survive the wrap
    @(negedge clk);
    order_intlv = 1'b0;
    cyc(1'b1, 1'b0, 20'hFFFFF);
    cyc(1'b1, 1'b1, 20'h00000);
    chk("R6 upper fixed on wrap", word_addr, 20'hFFFFC);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule